// File: doc/BRIEF.md
# Mixed Fixed/Round-Robin Channel Arbiter

This block decides which of several DMA channels may drive a single shared memory master. A channel takes part when it has a pending request and is enabled. Each channel belongs to one of two priority classes: fixed or round-robin. Software moves a channel between the classes through two strobe vectors. One strobe only sets the fixed class and the other only clears it. The resulting class vector can be read back.

Any eligible fixed-class channel beats every round-robin channel. Among fixed-class channels, the lowest index wins. Round-robin channels take turns in a rotating order. The grant is registered and one-hot.

Once granted, a channel keeps the grant for a burst whose length comes from its own 3-bit code. The burst length counts in beat-complete pulses. The channel gives the grant up earlier if its request drops or its enable is removed. When the grant is released, a new winner is picked on the same clock edge.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset `grant` is all zero and `prio_fixed` is all zero. The round-robin pointer starts so that channel 0 is the first round-robin channel served.
- R2: A 1 on bit n of `prio_set` makes `prio_fixed[n]` read 1 from the next cycle on. A 0 bit leaves the class of that channel unchanged. `prio_fixed[n]` reads 1 for a fixed-class channel and 0 for a round-robin one.
- R3: A 1 on bit n of `prio_clr` returns channel n to round-robin, so `prio_fixed[n]` reads 0 from the next cycle on. A 0 bit has no effect. If both strobes hit the same bit in the same cycle, the clear wins.
- R4: `grant` is zero or one-hot. A new grant appears one clock after the inputs that produced it. It only goes to a channel whose `req_act` and `ch_en` bits were both 1 at the picking edge. A channel that is not enabled is never granted.
- R5: When any eligible channel is fixed-class, the new grant goes to the lowest-indexed eligible fixed-class channel, whatever round-robin channels request.
- R6: When no eligible channel is fixed-class, the grant goes to the first eligible round-robin channel in ascending circular order. The search starts just after the round-robin channel that was granted last.
- R7: The burst code of a channel gives its burst length as 128 >> code beats: code 0 means 128 beats and code 7 means 1 beat. The granted channel keeps the grant until it has received that many `beat_done` pulses. On the edge of the last pulse, a new pick is made from the inputs at that edge.
- R8: If the granted channel loses `req_act` or `ch_en` before its burst ends, its grant is released at the next edge and a new pick is made at that edge.
- R9: A holder is never pre-empted before its burst ends. This holds when a higher-priority request arrives and when a priority-class change happens. `beat_done` pulses while nothing is granted have no effect on the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_act | input | NCH | Per-channel pending request |
| ch_en | input | NCH | Per-channel enable |
| prio_set | input | NCH | Write-1-to-set strobe for the fixed class |
| prio_clr | input | NCH | Write-1-to-clear strobe for the fixed class |
| burst_code | input | NCH*CODE_W | Per-channel burst code, channel n in bits [n*CODE_W +: CODE_W] |
| beat_done | input | 1 | One beat of the granted channel completed |
| grant | output | NCH | One-hot grant to the winning channel |
| prio_fixed | output | NCH | Readable class state, 1 = fixed |

## Verification
The bench drives a mixed set of requests, with lower-indexed round-robin channels requesting beside fixed ones. A design that ranked plain index above class, or that picked the highest fixed channel, would grant the wrong channel.

Rotation is checked both with every channel requesting and with gaps in the request set. A pointer that restarted at channel 0, or that failed to skip idle channels, shows up as a wrong grant order.

Bursts of 4 and of the full 128 beats are counted to the exact edge, which exposes off-by-one counters and a reversed code decode. Further cases are the same-cycle set and clear, beats during idle, and a higher-priority arrival mid-burst. A design that let set win, counted idle beats, or pre-empted the holder would fail these.

// File: rtl/dca_pkg.sv
package dca_pkg;

   // Beats in one burst for a given burst code: the largest burst halves per code step.
   function automatic int unsigned dca_burst_beats(input int unsigned code,
                                                   input int unsigned max_log2);
      return (32'd1 << max_log2) >> code;
   endfunction

endpackage

// File: rtl/dca_prio_reg.sv
module dca_prio_reg #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_i,
   input  logic [NCH-1:0] clr_i,
   output logic [NCH-1:0] fixed_o
);

   logic [NCH-1:0] fixed_q;

   // Clear is applied after set so a simultaneous clear wins.
   always_ff @(posedge clk) begin
      if (!rst_n) fixed_q <= '0;
      else        fixed_q <= (fixed_q | set_i) & ~clr_i;
   end

   assign fixed_o = fixed_q;

endmodule

// File: rtl/dca_picker.sv
module dca_picker #(
   parameter int NCH   = 4,
   parameter int IDX_W = 2
) (
   input  logic [NCH-1:0]   elig_i,
   input  logic [NCH-1:0]   fixed_i,
   input  logic [IDX_W-1:0] rr_last_i,
   output logic [NCH-1:0]   pick_vec_o,
   output logic [IDX_W-1:0] pick_idx_o,
   output logic             pick_valid_o,
   output logic             pick_rr_o
);

   logic [NCH-1:0] fx_req;
   logic [NCH-1:0] rr_req;

   assign fx_req = elig_i & fixed_i;
   assign rr_req = elig_i & ~fixed_i;

   always_comb begin
      int unsigned idx;
      pick_vec_o   = '0;
      pick_idx_o   = '0;
      pick_valid_o = 1'b0;
      pick_rr_o    = 1'b0;
      // fixed class: lowest index first
      for (int i = 0; i < NCH; i++) begin
         if (!pick_valid_o && fx_req[i]) begin
            pick_vec_o[i] = 1'b1;
            pick_idx_o    = IDX_W'(i);
            pick_valid_o  = 1'b1;
         end
      end
      // round-robin class: circular search after the last served channel
      for (int k = 1; k <= NCH; k++) begin
         idx = (int'(rr_last_i) + k) % NCH;
         if (!pick_valid_o && rr_req[idx]) begin
            pick_vec_o[idx] = 1'b1;
            pick_idx_o      = IDX_W'(idx);
            pick_valid_o    = 1'b1;
            pick_rr_o       = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dca_beat_ctr.sv
module dca_beat_ctr #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             beat_i,
   output logic             last_o
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       left_q <= '0;
      else if (load_i)                  left_q <= load_val_i;
      else if (beat_i && left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign last_o = (left_q == '0);

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
   parameter int NCH      = 4,
   parameter int CODE_W   = 3,
   parameter int MAX_LOG2 = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        req_act,
   input  logic [NCH-1:0]        ch_en,
   input  logic [NCH-1:0]        prio_set,
   input  logic [NCH-1:0]        prio_clr,
   input  logic [NCH*CODE_W-1:0] burst_code,
   input  logic                  beat_done,
   output logic [NCH-1:0]        grant,
   output logic [NCH-1:0]        prio_fixed
);

   localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("dma_chan_arbiter: NCH must be at least 2");
      end
      if ((1 << CODE_W) != MAX_LOG2 + 1) begin : g_bad_code
         $error("dma_chan_arbiter: code width must span burst sizes 1 to 2**MAX_LOG2");
      end
   endgenerate

   logic [NCH-1:0]   elig;
   logic [NCH-1:0]   grant_q;
   logic [IDX_W-1:0] rr_last_q;
   logic [NCH-1:0]   pick_vec;
   logic [IDX_W-1:0] pick_idx;
   logic             pick_valid;
   logic             pick_rr;
   logic             burst_last;
   logic             holder_ok;
   logic             release_now;
   logic             open_pick;
   logic [CNT_W-1:0] beats_last [NCH];

   // per-channel decode of burst code into (beats - 1)
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_decode
         assign beats_last[c] = CNT_W'(dca_pkg::dca_burst_beats(
                                   int'(burst_code[c*CODE_W +: CODE_W]), MAX_LOG2) - 1);
      end
   endgenerate

   dca_prio_reg #(.NCH(NCH)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (prio_set),
      .clr_i   (prio_clr),
      .fixed_o (prio_fixed)
   );

   assign elig = req_act & ch_en;

   dca_picker #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
      .elig_i       (elig),
      .fixed_i      (prio_fixed),
      .rr_last_i    (rr_last_q),
      .pick_vec_o   (pick_vec),
      .pick_idx_o   (pick_idx),
      .pick_valid_o (pick_valid),
      .pick_rr_o    (pick_rr)
   );

   assign holder_ok   = |(grant_q & elig);
   assign release_now = (grant_q != '0) && (!holder_ok || (beat_done && burst_last));
   assign open_pick   = (grant_q == '0) || release_now;

   dca_beat_ctr #(.CNT_W(CNT_W)) u_beats (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (open_pick && pick_valid),
      .load_val_i (beats_last[pick_idx]),
      .beat_i     (beat_done && (grant_q != '0)),
      .last_o     (burst_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q   <= '0;
         rr_last_q <= IDX_W'(NCH - 1);
      end else if (open_pick) begin
         grant_q <= pick_vec;
         if (pick_valid && pick_rr) rr_last_q <= pick_idx;
      end
   end

   assign grant = grant_q;

endmodule

// File: rtl/dca_arbiter_chk.sv
module dca_arbiter_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] req_act,
   input logic [NCH-1:0] ch_en,
   input logic [NCH-1:0] prio_set,
   input logic [NCH-1:0] prio_clr,
   input logic           beat_done,
   input logic [NCH-1:0] grant,
   input logic [NCH-1:0] prio_fixed
);

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R4

   AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != $past(grant) && grant != '0) |-> ((grant & $past(req_act & ch_en)) != '0)); // R4

   AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != $past(grant) && grant != '0 && (grant & $past(prio_fixed)) == '0)
         |-> ($past(req_act & ch_en & prio_fixed) == '0)); // R5

   AST_HOLD_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(grant & req_act & ch_en)) && !beat_done) |=> $stable(grant)); // R9

   AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant & ~(req_act & ch_en))) |=> !$stable(grant)); // R8

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(prio_set & ~prio_clr)) |=>
         ((prio_fixed & $past(prio_set & ~prio_clr)) == $past(prio_set & ~prio_clr))); // R2

   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|prio_clr) |=> ((prio_fixed & $past(prio_clr)) == '0)); // R3

endmodule

bind dma_chan_arbiter dca_arbiter_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_act    (req_act),
   .ch_en      (ch_en),
   .prio_set   (prio_set),
   .prio_clr   (prio_clr),
   .beat_done  (beat_done),
   .grant      (grant),
   .prio_fixed (prio_fixed)
);

// File: tb/tb_dma_chan_arbiter.sv
`timescale 1ns/1ps
module tb_dma_chan_arbiter;

   localparam int NCH = 4;
   localparam int CW  = 3;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [NCH-1:0] req_act, ch_en, prio_set, prio_clr;
   logic [NCH*CW-1:0] burst_code;
   logic           beat_done;
   logic [NCH-1:0] grant, prio_fixed;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dma_chan_arbiter #(.NCH(NCH), .CODE_W(CW), .MAX_LOG2(7)) dut (
      .clk(clk), .rst_n(rst_n), .req_act(req_act), .ch_en(ch_en),
      .prio_set(prio_set), .prio_clr(prio_clr), .burst_code(burst_code),
      .beat_done(beat_done), .grant(grant), .prio_fixed(prio_fixed));

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic set_code(input int ch, input logic [CW-1:0] c);
      burst_code[ch*CW +: CW] = c;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_act = '0; ch_en = '0; prio_set = '0; prio_clr = '0;
      beat_done = 1'b0; burst_code = {NCH{3'd7}};
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 grant after reset", 32'(grant), 32'h0);
      chk("R1 prio after reset", 32'(prio_fixed), 32'h0);
   endtask

   task automatic t_prio_regs();
      do_reset();
      prio_set = 4'b0101; tick(); prio_set = '0;
      chk("R2 set 0101", 32'(prio_fixed), 32'h5);
      tick();
      chk("R2 zero set no effect", 32'(prio_fixed), 32'h5);
      prio_clr = 4'b0001; tick(); prio_clr = '0;
      chk("R3 clear ch0", 32'(prio_fixed), 32'h4);
      prio_set = 4'b1000; prio_clr = 4'b1000; tick();
      prio_set = '0; prio_clr = '0;
      chk("R3 clear wins", 32'(prio_fixed), 32'h4);
      tick();
      chk("R3 zero clear no effect", 32'(prio_fixed), 32'h4);
   endtask

   task automatic t_rr_rotation();
      do_reset();
      req_act = 4'b1111; ch_en = 4'b1111;
      tick();
      chk("R6 first rr is ch0", 32'(grant), 32'h1);
      beat_done = 1'b1;
      tick(); chk("R6 rotate ch1", 32'(grant), 32'h2);
      tick(); chk("R6 rotate ch2", 32'(grant), 32'h4);
      tick(); chk("R6 rotate ch3", 32'(grant), 32'h8);
      tick(); chk("R6 wrap ch0", 32'(grant), 32'h1);
      req_act = 4'b0101;
      tick(); chk("R6 skip ch1", 32'(grant), 32'h4);
      tick(); chk("R6 skip ch3", 32'(grant), 32'h1);
      beat_done = 1'b0;
   endtask

   task automatic t_fixed();
      do_reset();
      prio_set = 4'b1100; tick(); prio_set = '0;
      req_act = 4'b1101; ch_en = 4'b1111;
      tick();
      chk("R5 lowest fixed ch2 beats rr ch0", 32'(grant), 32'h4);
      req_act = 4'b1001;
      tick();
      chk("R8 request drop releases to fixed ch3", 32'(grant), 32'h8);
      beat_done = 1'b1;
      tick(); beat_done = 1'b0;
      chk("R5 fixed ch3 regranted over rr", 32'(grant), 32'h8);
      req_act = 4'b0001;
      tick();
      chk("R5 rr ch0 once no fixed", 32'(grant), 32'h1);
   endtask

   task automatic t_burst_len();
      do_reset();
      set_code(1, 3'd5);
      req_act = 4'b0010; ch_en = 4'b1111;
      tick();
      chk("R7 ch1 granted", 32'(grant), 32'h2);
      req_act = 4'b0110; beat_done = 1'b1;
      for (int b = 0; b < 3; b++) tick();
      chk("R7 held after 3 of 4 beats", 32'(grant), 32'h2);
      tick();
      chk("R7 released after 4th beat", 32'(grant), 32'h4);
      beat_done = 1'b0;

      do_reset();
      set_code(0, 3'd0);
      req_act = 4'b0011; ch_en = 4'b1111;
      tick();
      beat_done = 1'b1;
      for (int b = 0; b < 127; b++) tick();
      chk("R7 held after 127 of 128 beats", 32'(grant), 32'h1);
      tick();
      chk("R7 released after 128th beat", 32'(grant), 32'h2);
      beat_done = 1'b0;
   endtask

   task automatic t_enable_drop();
      do_reset();
      burst_code = '0;
      req_act = 4'b1001; ch_en = 4'b1111;
      tick();
      chk("R8 ch0 granted", 32'(grant), 32'h1);
      ch_en = 4'b1110;
      tick();
      chk("R8 enable drop releases to ch3", 32'(grant), 32'h8);
   endtask

   task automatic t_no_preempt();
      do_reset();
      burst_code = '0;
      req_act = 4'b0001; ch_en = 4'b1111;
      tick();
      prio_set = 4'b0010; req_act = 4'b0011;
      tick(); prio_set = '0;
      chk("R9 fixed arrival does not preempt", 32'(grant), 32'h1);
      prio_set = 4'b0001; beat_done = 1'b1;
      tick(); prio_set = '0; beat_done = 1'b0;
      chk("R9 class change does not preempt", 32'(grant), 32'h1);
      req_act = 4'b0010;
      tick();
      chk("R8 release goes to ch1", 32'(grant), 32'h2);
   endtask

   task automatic t_disabled_idle();
      do_reset();
      req_act = 4'b0100; ch_en = 4'b1011; beat_done = 1'b1;
      tick(); tick(); tick();
      chk("R4 disabled channel never granted", 32'(grant), 32'h0);
      beat_done = 1'b0; ch_en = 4'b1111; set_code(2, 3'd6);
      tick();
      chk("R4 granted one edge after enable", 32'(grant), 32'h4);
      req_act = 4'b0101; beat_done = 1'b1;
      tick();
      chk("R9 idle beats ignored, still held after 1 of 2", 32'(grant), 32'h4);
      tick();
      chk("R7 two-beat burst ends, ch0 next", 32'(grant), 32'h1);
      beat_done = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_prio_regs();
      t_rr_rotation();
      t_fixed();
      t_burst_len();
      t_enable_drop();
      t_no_preempt();
      t_disabled_idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule